// File: doc/BRIEF.md
# DDR SDRAM Initialization Command Sequencer

This block sits at the front of a memory controller during DDR SDRAM bring-up. A host writes 4-bit command codes over a valid/ready handshake. The block turns each accepted code into one command on a simplified memory command bus: active-low chip select, row strobe, column strobe, write enable, a bank address and a row/column address. While a command is not being issued, the bus carries a NOP.

After each mode-register-set, precharge-all or auto-refresh, an internal down-counter holds the ready flag low for that command's minimum spacing. A host write that arrives inside the gap is held, not dropped, and it is issued in the first cycle the spacing allows. The mode-register command carries a fixed burst length of four, sequential wrapping and a CAS latency of either 2 or 2.5. A dedicated code switches the block into normal operation. An unknown code issues a NOP and raises a one-cycle error pulse.

The host sequence this block is built for is: mode-register-set, precharge-all, two auto-refreshes, mode-register-set, then normal operation.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is high, and in the cycle after it falls, the bus shows NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1, bank 0, address 0), ready is 1, normal_mode is 0 and bad_cmd is 0.
- R2: Code 4'b0100 puts a precharge-all on the bus: cs_n=0, ras_n=0, cas_n=1, we_n=0, address bit 10 set, all other address bits 0, bank 0.
- R3: Code 4'b0111 puts an auto-refresh on the bus: cs_n=0, ras_n=0, cas_n=0, we_n=1, address 0, bank 0.
- R4: Codes 4'b0000 and 4'b0001 put a mode-register-set on the bus: all four strobes low and bank 0. The address is laid out as follows:
  - bits [2:0] = 3'b010, for a burst of four;
  - bit 3 = 0, for sequential wrap;
  - bits [6:4] = 3'b010 for code 0000 (CAS latency 2) or 3'b110 for code 0001 (CAS latency 2.5);
  - bit 8 = 0, so the DLL is not reset;
  - every other address bit is 0.
- R5: After a mode-register-set is accepted, the next acceptance comes no earlier than T_MRD cycles later.
- R6: After a precharge-all is accepted, the next acceptance comes no earlier than T_RP cycles later.
- R7: After an auto-refresh is accepted, the next acceptance of any command comes no earlier than T_RFC cycles later.
- R8: A code held valid while ready is low is accepted in exactly the first cycle its gap allows. Each held write is issued exactly once.
- R9: Code 4'b1111 sets normal_mode, which stays set until reset. It leaves NOP on the bus and imposes no gap.
- R10: Any other code leaves NOP on the bus, imposes no gap, and raises bad_cmd in the cycle after acceptance only.
- R11: An accepted command shows on the bus in the cycle after its acceptance edge. The bus returns to NOP in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Host presents a command code |
| cmd_code | input | 4 | Command code from the host |
| cmd_ready | output | 1 | Block can accept a code this cycle |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ba | output | BA_W | Bank address |
| mem_addr | output | ADDR_W | Address / mode word |
| normal_mode | output | 1 | Normal operation reached |
| bad_cmd | output | 1 | One-cycle pulse for an unknown code |

## Verification
The bench builds the block with T_MRD=4, T_RP=4, T_RFC=16, ADDR_W=13 and BA_W=2. With these values the three gaps give stall counts of 3, 3 and 15 cycles, so a gap assigned to the wrong command shows up as a wrong acceptance cycle. Random idle spacing from 0 to 20 cycles lands both inside and beyond the 16-cycle refresh window, which covers both stalled writes and writes that arrive after the gap has expired. The 13-bit address exposes bit 10 and the upper mode-word bits that must stay zero.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  typedef enum logic [2:0] {
    OP_MRS,
    OP_PRE,
    OP_REF,
    OP_RUN,
    OP_BAD
  } op_e;

  // strobe order {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CTL_NOP = 4'b0111;
  localparam logic [3:0] CTL_MRS = 4'b0000;
  localparam logic [3:0] CTL_PRE = 4'b0010;
  localparam logic [3:0] CTL_REF = 4'b0001;

  localparam logic [3:0] CODE_MRS_CL2  = 4'b0000;
  localparam logic [3:0] CODE_MRS_CL25 = 4'b0001;
  localparam logic [3:0] CODE_PRE      = 4'b0100;
  localparam logic [3:0] CODE_REF      = 4'b0111;
  localparam logic [3:0] CODE_RUN      = 4'b1111;

  localparam logic [2:0] BURST4_FIELD = 3'b010;
  localparam logic [2:0] LAT2_FIELD   = 3'b010;
  localparam logic [2:0] LAT25_FIELD  = 3'b110;

  function automatic op_e op_of(input logic [3:0] code);
    case (code)
      CODE_MRS_CL2, CODE_MRS_CL25: op_of = OP_MRS;
      CODE_PRE:                    op_of = OP_PRE;
      CODE_REF:                    op_of = OP_REF;
      CODE_RUN:                    op_of = OP_RUN;
      default:                     op_of = OP_BAD;
    endcase
  endfunction

endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
  import ddr_init_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2,
  parameter int CNT_W  = 5,
  parameter int T_MRD  = 4,
  parameter int T_RP   = 4,
  parameter int T_RFC  = 16
) (
  input  logic [3:0]        code,
  output op_e               op,
  output logic [3:0]        ctl,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic [CNT_W-1:0]  wait_len
);

  localparam logic [CNT_W-1:0] WAIT_MRD = CNT_W'(T_MRD - 1);
  localparam logic [CNT_W-1:0] WAIT_RP  = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0] WAIT_RFC = CNT_W'(T_RFC - 1);

  always_comb begin
    op       = op_of(code);
    ctl      = CTL_NOP;
    ba       = '0;
    addr     = '0;
    wait_len = '0;
    case (op)
      OP_MRS: begin
        ctl       = CTL_MRS;
        addr[2:0] = BURST4_FIELD;
        addr[3]   = 1'b0;
        addr[6:4] = code[0] ? LAT25_FIELD : LAT2_FIELD;
        wait_len  = WAIT_MRD;
      end
      OP_PRE: begin
        ctl      = CTL_PRE;
        addr[10] = 1'b1;
        wait_len = WAIT_RP;
      end
      OP_REF: begin
        ctl      = CTL_REF;
        wait_len = WAIT_RFC;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/ddr_gap_timer.sv
module ddr_gap_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] len,
  output logic             expired
);

  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (rst)
      remain_q <= '0;
    else if (load)
      remain_q <= len;
    else if (remain_q != '0)
      remain_q <= remain_q - 1'b1;
  end

  assign expired = (remain_q == '0);

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2,
  parameter int T_MRD  = 4,
  parameter int T_RP   = 4,
  parameter int T_RFC  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [3:0]        cmd_code,
  output logic              cmd_ready,
  output logic              mem_cs_n,
  output logic              mem_ras_n,
  output logic              mem_cas_n,
  output logic              mem_we_n,
  output logic [BA_W-1:0]   mem_ba,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              normal_mode,
  output logic              bad_cmd
);

  localparam int T_MAX1 = (T_MRD > T_RP) ? T_MRD : T_RP;
  localparam int T_MAX  = (T_MAX1 > T_RFC) ? T_MAX1 : T_RFC;
  localparam int CNT_W  = $clog2(T_MAX) + 1;

  op_e               dec_op;
  logic [3:0]        dec_ctl;
  logic [BA_W-1:0]   dec_ba;
  logic [ADDR_W-1:0] dec_addr;
  logic [CNT_W-1:0]  dec_wait;
  logic              gap_done;
  logic              accept;

  logic [3:0]        ctl_q;
  logic [BA_W-1:0]   ba_q;
  logic [ADDR_W-1:0] addr_q;
  logic              run_q;
  logic              bad_q;

  ddr_cmd_decode #(
    .ADDR_W(ADDR_W), .BA_W(BA_W), .CNT_W(CNT_W),
    .T_MRD(T_MRD), .T_RP(T_RP), .T_RFC(T_RFC)
  ) decode_i (
    .code     (cmd_code),
    .op       (dec_op),
    .ctl      (dec_ctl),
    .ba       (dec_ba),
    .addr     (dec_addr),
    .wait_len (dec_wait)
  );

  assign accept = cmd_valid && gap_done;

  ddr_gap_timer #(.CNT_W(CNT_W)) timer_i (
    .clk     (clk),
    .rst     (rst),
    .load    (accept),
    .len     (dec_wait),
    .expired (gap_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= CTL_NOP;
      ba_q   <= '0;
      addr_q <= '0;
      run_q  <= 1'b0;
      bad_q  <= 1'b0;
    end else begin
      bad_q <= accept && (dec_op == OP_BAD);
      if (accept && (dec_op == OP_RUN))
        run_q <= 1'b1;
      if (accept) begin
        ctl_q  <= dec_ctl;
        ba_q   <= dec_ba;
        addr_q <= dec_addr;
      end else begin
        ctl_q  <= CTL_NOP;
        ba_q   <= '0;
        addr_q <= '0;
      end
    end
  end

  assign cmd_ready   = gap_done;
  assign mem_cs_n    = ctl_q[3];
  assign mem_ras_n   = ctl_q[2];
  assign mem_cas_n   = ctl_q[1];
  assign mem_we_n    = ctl_q[0];
  assign mem_ba      = ba_q;
  assign mem_addr    = addr_q;
  assign normal_mode = run_q;
  assign bad_cmd     = bad_q;

endmodule

// File: rtl/ddr_init_seq_chk.sv
module ddr_init_seq_chk #(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2,
  parameter int T_MRD  = 4,
  parameter int T_RP   = 4,
  parameter int T_RFC  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              ready,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [BA_W-1:0]   ba,
  input logic [ADDR_W-1:0] addr,
  input logic              run,
  input logic              bad
);

  localparam int SW = $clog2(T_RFC + 2) + 1;
  localparam logic [SW-1:0] LIM_MRD = SW'(T_MRD);
  localparam logic [SW-1:0] LIM_RP  = SW'(T_RP);
  localparam logic [SW-1:0] LIM_RFC = SW'(T_RFC);
  localparam logic [ADDR_W-1:0] MRS_FREE = ADDR_W'(7'h77);

  logic is_nop, is_mrs, is_pre, is_ref, is_cmd;
  assign is_nop = !cs_n && ras_n && cas_n && we_n;
  assign is_mrs = !cs_n && !ras_n && !cas_n && !we_n;
  assign is_pre = !cs_n && !ras_n && cas_n && !we_n;
  assign is_ref = !cs_n && !ras_n && !cas_n && we_n;
  assign is_cmd = is_mrs || is_pre || is_ref;

  // cycles since the last command shown on the bus, and its kind
  logic [SW-1:0] since_q;
  logic [1:0]    last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_q <= '0;
      last_q  <= 2'd0;
    end else if (is_cmd) begin
      since_q <= SW'(1);
      last_q  <= is_mrs ? 2'd1 : (is_pre ? 2'd2 : 2'd3);
    end else if (since_q != '0 && since_q < LIM_RFC) begin
      since_q <= since_q + 1'b1;
    end
  end

  p_gap_mrd_r5: assert property (@(posedge clk) disable iff (rst)
    (is_cmd && last_q == 2'd1) |-> (since_q >= LIM_MRD));

  p_gap_rp_r6: assert property (@(posedge clk) disable iff (rst)
    (is_cmd && last_q == 2'd2) |-> (since_q >= LIM_RP));

  p_gap_rfc_r7: assert property (@(posedge clk) disable iff (rst)
    (is_cmd && last_q == 2'd3) |-> (since_q >= LIM_RFC));

  p_busy_on_issue_r8: assert property (@(posedge clk) disable iff (rst)
    is_cmd |-> !ready);

  p_mrs_word_r4: assert property (@(posedge clk) disable iff (rst)
    is_mrs |-> (ba == '0 && addr[2:0] == 3'b010 && addr[3] == 1'b0 &&
                (addr[6:4] == 3'b010 || addr[6:4] == 3'b110) &&
                (addr & ~MRS_FREE) == '0));

  p_pre_all_r2: assert property (@(posedge clk) disable iff (rst)
    is_pre |-> (addr[10] && ba == '0));

  p_run_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    run |=> run);

  p_bad_is_nop_r10: assert property (@(posedge clk) disable iff (rst)
    bad |-> is_nop);

  p_single_cycle_r11: assert property (@(posedge clk) disable iff (rst)
    is_cmd |=> is_nop);

  p_bus_legal_r11: assert property (@(posedge clk) disable iff (rst)
    (is_nop || is_cmd));

endmodule

bind ddr_init_seq ddr_init_seq_chk #(
  .ADDR_W(ADDR_W), .BA_W(BA_W), .T_MRD(T_MRD), .T_RP(T_RP), .T_RFC(T_RFC)
) chk_i (
  .clk   (clk),
  .rst   (rst),
  .ready (cmd_ready),
  .cs_n  (mem_cs_n),
  .ras_n (mem_ras_n),
  .cas_n (mem_cas_n),
  .we_n  (mem_we_n),
  .ba    (mem_ba),
  .addr  (mem_addr),
  .run   (normal_mode),
  .bad   (bad_cmd)
);

// File: tb/ddr_init_seq_tb_top.sv
module ddr_init_seq_tb_top;

  localparam int ADDR_W = 13;
  localparam int BA_W   = 2;
  localparam int T_MRD  = 4;
  localparam int T_RP   = 4;
  localparam int T_RFC  = 16;
  localparam int BW     = 4 + BA_W + ADDR_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cmd_valid = 1'b0;
  logic [3:0]        cmd_code = 4'h0;
  logic              cmd_ready;
  logic              mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n;
  logic [BA_W-1:0]   mem_ba;
  logic [ADDR_W-1:0] mem_addr;
  logic              normal_mode;
  logic              bad_cmd;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit done     = 1'b0;

  int         last_acc  = -100;
  int         last_gap  = 0;
  logic [3:0] last_code = 4'hA;
  bit         exp_run   = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ddr_init_seq #(
    .ADDR_W(ADDR_W), .BA_W(BA_W), .T_MRD(T_MRD), .T_RP(T_RP), .T_RFC(T_RFC)
  ) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_ready(cmd_ready), .mem_cs_n(mem_cs_n), .mem_ras_n(mem_ras_n),
    .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n), .mem_ba(mem_ba),
    .mem_addr(mem_addr), .normal_mode(normal_mode), .bad_cmd(bad_cmd)
  );

  function automatic logic [BW-1:0] nop_word();
    return {4'b0111, {BA_W{1'b0}}, {ADDR_W{1'b0}}};
  endfunction

  function automatic logic [BW-1:0] exp_bus(input logic [3:0] code);
    logic [ADDR_W-1:0] a;
    a = '0;
    case (code)
      4'b0000: begin a[6:0] = 7'b0100010; return {4'b0000, {BA_W{1'b0}}, a}; end
      4'b0001: begin a[6:0] = 7'b1100010; return {4'b0000, {BA_W{1'b0}}, a}; end
      4'b0100: begin a[10] = 1'b1;        return {4'b0010, {BA_W{1'b0}}, a}; end
      4'b0111:                             return {4'b0001, {BA_W{1'b0}}, a};
      default:                             return nop_word();
    endcase
  endfunction

  function automatic int gap_of(input logic [3:0] code);
    case (code)
      4'b0000, 4'b0001: return T_MRD;
      4'b0100:          return T_RP;
      4'b0111:          return T_RFC;
      default:          return 1;
    endcase
  endfunction

  function automatic string bus_req(input logic [3:0] code);
    case (code)
      4'b0000, 4'b0001: return "R4";
      4'b0100:          return "R2";
      4'b0111:          return "R3";
      4'b1111:          return "R9";
      default:          return "R10";
    endcase
  endfunction

  function automatic string gap_req(input logic [3:0] code);
    case (code)
      4'b0000, 4'b0001: return "R5";
      4'b0100:          return "R6";
      4'b0111:          return "R7";
      4'b1111:          return "R9";
      default:          return "R10";
    endcase
  endfunction

  function automatic bit is_bad(input logic [3:0] code);
    return !(code == 4'b0000 || code == 4'b0001 || code == 4'b0100 ||
             code == 4'b0111 || code == 4'b1111);
  endfunction

  function automatic logic [BW-1:0] bus_now();
    return {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n, mem_ba, mem_addr};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic issue(input logic [3:0] code);
    int c;
    int earliest;
    int acc;
    string treq;
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_code  = code;
    c = cyc;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    #1;
    acc = cyc;
    cmd_valid = 1'b0;
    earliest = (c + 1 > last_acc + last_gap) ? c + 1 : last_acc + last_gap;
    treq = (earliest > c + 1) ? {gap_req(last_code), " R8"} : {gap_req(last_code), " R11"};
    chk(acc == earliest, treq, acc, earliest);
    chk(bus_now() == exp_bus(code), {bus_req(code), " R11"}, bus_now(), exp_bus(code));
    if (code == 4'b1111) exp_run = 1'b1;
    chk(normal_mode == exp_run, "R9", normal_mode, exp_run);
    chk(bad_cmd == is_bad(code), "R10", bad_cmd, is_bad(code));
    last_acc  = acc;
    last_gap  = gap_of(code);
    last_code = code;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
      chk(bus_now() == nop_word(), "R11", bus_now(), nop_word());
      chk(bad_cmd == 1'b0, "R10", bad_cmd, 0);
      chk(normal_mode == exp_run, "R9", normal_mode, exp_run);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0DD1));
    repeat (3) @(posedge clk);
    #1;
    // R1 in reset
    chk(bus_now() == nop_word(), "R1", bus_now(), nop_word());
    chk(cmd_ready == 1'b1, "R1", cmd_ready, 1);
    chk(normal_mode == 1'b0, "R1", normal_mode, 0);
    chk(bad_cmd == 1'b0, "R1", bad_cmd, 0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    chk(bus_now() == nop_word(), "R1", bus_now(), nop_word());
    chk(cmd_ready == 1'b1, "R1", cmd_ready, 1);

    // directed bring-up, host writes back to back so every gap stalls
    issue(4'b0000);
    issue(4'b0100);
    issue(4'b0111);
    issue(4'b0111);
    issue(4'b0000);
    issue(4'b1111);
    idle(3);

    // CAS latency 2.5, then single-cycle bus return to NOP
    issue(4'b0001);
    idle(1);
    issue(4'b0100);
    idle(T_RP + 2);

    // unknown codes back to back: no gap, pulse per acceptance
    issue(4'b1010);
    issue(4'b0011);
    idle(2);
    issue(4'b1111);
    issue(4'b0111);
    idle(T_RFC + 1);

    // random mix
    for (int i = 0; i < 300; i++) begin
      int r;
      logic [3:0] code;
      r = $urandom % 10;
      case (r)
        0: code = 4'b0000;
        1: code = 4'b0001;
        2: code = 4'b0100;
        3, 4: code = 4'b0111;
        5: code = 4'b1111;
        default: code = 4'($urandom % 16);
      endcase
      issue(code);
      if (($urandom % 3) != 0) idle($urandom % 21);
    end

    idle(2);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule